// File: doc/BRIEF.md
# Set-Associative Tag Directory with Rank-Based Replacement

This block keeps the tag side of a set-associative cache. Every entry has a stored tag, a valid flag, a dirty flag, a lock flag and a small recency rank. A lookup request carries an address. One clock later the block reports whether the address hit, which way it hit, or which way should be replaced. Each lookup also reports the dirty flag of the chosen way, so the surrounding controller can decide whether a writeback is needed. Line data, refill sequencing and the memory bus belong to the surrounding cache and are not part of this block.

A separate update port installs a tag into a way or marks a way dirty, and it always makes that way the most recent in its set. A control port locks, unlocks or invalidates a single way. A one-way input turns the array into a direct-mapped structure. In that structure the low bits of the tag field choose the way, so the block behaves as if it had sets × ways sets of a single line each. Two counters record how many lookups were made and how many of them hit.

Top module: `tagl_lookup`

## Requirements
- R1: The set index is address bits [OFF_W+SET_W-1:OFF_W], where OFF_W = log2(line bytes) and SET_W = log2(sets). The stored tag is every address bit above those. Offset bits never affect a result.
- R2: A lookup hits when an entry of the indexed set is valid and its stored tag equals the address tag. res_way then gives the lowest-numbered such way, and res_way_ok is 1.
- R3: On a miss, res_way is the unlocked way with the smallest rank, with ties going to the lower way number. A locked way is never offered, even when it is invalid.
- R4: On a miss in a set whose usable ways are all locked, res_way_ok is 0. A hit on a locked way still reports the hit with res_way_ok = 1.
- R5: In normal mode, an update to a way first decrements by one every rank in that set that is larger than the updated way's rank. The updated way's rank then becomes WAYS.
- R6: acc_count increments once for every accepted lookup. hit_count increments once for every lookup that hits. Both counters appear together with the result.
- R7: After reset, every valid, dirty and lock flag is 0, way i of every set has rank i, and both counters are 0.
- R8: While one_way is 1, address bits [OFF_W+SET_W+WAY_W-1:OFF_W+SET_W] select the way for lookups, updates and controls. upd_way and ctl_way are ignored, ranks are not changed, and a miss offers that way unless it is locked. When one_way returns to 0, normal associative behaviour resumes on the same contents.
- R9: res_valid is 1 exactly in the cycle after a cycle with lk_valid = 1. A lookup sees the state from before any update or control issued in the same cycle.
- R10: An update with upd_fill = 1 stores the tag, sets valid, and sets dirty to upd_dirty. An update with upd_fill = 0 ORs upd_dirty into the dirty flag. res_dirty shows the dirty flag of res_way when res_way_ok = 1.
- R11: ctl_op encodings are 0 = lock, 1 = unlock, 2 = invalidate and 3 = no operation. Invalidate clears both valid and dirty.
- R12: When an update and a control target the same entry in the same cycle, the update is applied first and the control is applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| one_way | input | 1 | Direct-mapped mode select |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| upd_valid | input | 1 | Update request (most-recent mark) |
| upd_addr | input | ADDR_W | Update address (set and tag) |
| upd_way | input | WAY_W | Way to update in normal mode |
| upd_fill | input | 1 | Install the address tag and set valid |
| upd_dirty | input | 1 | Dirty value (fill) or dirty set (no fill) |
| ctl_valid | input | 1 | Control request |
| ctl_op | input | 2 | 0 lock, 1 unlock, 2 invalidate, 3 none |
| ctl_addr | input | ADDR_W | Control address (set) |
| ctl_way | input | WAY_W | Way to control in normal mode |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Lookup hit |
| res_way_ok | output | 1 | res_way is usable (hit or victim found) |
| res_way | output | WAY_W | Hit way or victim way |
| res_dirty | output | 1 | Dirty flag of res_way |
| acc_count | output | CNT_W | Lookups accepted |
| hit_count | output | CNT_W | Lookups that hit |

## Verification
The directed patterns each separate two behaviours. Lookups that differ only in offset, or only in tag bits, show which address bits count. A series of updates followed by misses shows the rank-ordered victim apart from plain way order. Lock patterns show a skipped invalid way, a set with every way locked, and a hit on a locked way. Same-cycle update, control and lookup combinations establish the order in which they take effect. One-way mode is tested with a way number that disagrees with the address, so the bench can tell whether upd_way was used or ignored. A long random mix over a few sets and tags, with mode switches, exercises rank aging and counter totals against the reference model.

// File: rtl/tagl_pkg.sv
package tagl_pkg;
    typedef enum logic [1:0] {
        CTL_LOCK   = 2'd0,
        CTL_UNLOCK = 2'd1,
        CTL_INVAL  = 2'd2,
        CTL_NONE   = 2'd3
    } ctl_op_e;
endpackage

// File: rtl/tagl_match.sv
module tagl_match #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 3,
    parameter int WAY_W  = 2
) (
    input  logic [WAYS-1:0]        valid_i,
    input  logic [WAYS-1:0]        lock_i,
    input  logic [WAYS-1:0]        tag_eq_i,
    input  logic [WAYS*RANK_W-1:0] rank_i,
    output logic                   hit_o,
    output logic [WAY_W-1:0]       hit_way_o,
    output logic                   vic_ok_o,
    output logic [WAY_W-1:0]       vic_way_o
);
    logic [RANK_W-1:0] best;

    // first matching way wins; victim is lowest rank among unlocked, first on ties
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        vic_ok_o  = 1'b0;
        vic_way_o = '0;
        best      = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit_o && valid_i[w] && tag_eq_i[w]) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
            if (!lock_i[w] && (!vic_ok_o || rank_i[w*RANK_W +: RANK_W] < best)) begin
                vic_ok_o  = 1'b1;
                vic_way_o = WAY_W'(w);
                best      = rank_i[w*RANK_W +: RANK_W];
            end
        end
    end
endmodule

// File: rtl/tagl_stats.sv
module tagl_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             look_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] acc_o,
    output logic [CNT_W-1:0] hits_o
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] hits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (look_i) begin
            st_d.acc = st_q.acc + CNT_W'(1);
            if (hit_i) st_d.hits = st_q.hits + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign hits_o = st_q.hits;

    p_acc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        look_i |=> acc_o == $past(acc_o) + CNT_W'(1));
    p_hits_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(look_i && hit_i) |=> $stable(hits_o));
endmodule

// File: rtl/tagl_lookup.sv
module tagl_lookup #(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 32,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              one_way,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic              upd_fill,
    input  logic              upd_dirty,
    input  logic              ctl_valid,
    input  logic [1:0]        ctl_op,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [WAY_W-1:0]  ctl_way,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_way_ok,
    output logic [WAY_W-1:0]  res_way,
    output logic              res_dirty,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  hit_count
);
    import tagl_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int RANK_W = $clog2(WAYS + 1);
    localparam int NENT   = SETS * WAYS;
    localparam int IX_W   = SET_W + WAY_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              valid;
        logic              dirty;
        logic              lock;
        logic [RANK_W-1:0] rank;
    } entry_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             ok;
        logic [WAY_W-1:0] way;
        logic             dirty;
    } result_t;

    entry_t  ent_d [NENT];
    entry_t  ent_q [NENT];
    result_t res_d, res_q;

    // ---------------- lookup decode ----------------
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAY_W-1:0] lk_ow;
    assign lk_set = lk_addr[OFF_W +: SET_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_ow  = lk_addr[OFF_W+SET_W +: WAY_W];

    logic [WAYS-1:0]        sv_valid, sv_lock, sv_dirty, sv_eq;
    logic [WAYS*RANK_W-1:0] sv_rank;

    for (genvar g = 0; g < WAYS; g++) begin : g_slice
        assign sv_valid[g] = ent_q[{lk_set, WAY_W'(g)}].valid;
        assign sv_lock[g]  = ent_q[{lk_set, WAY_W'(g)}].lock;
        assign sv_dirty[g] = ent_q[{lk_set, WAY_W'(g)}].dirty;
        assign sv_eq[g]    = ent_q[{lk_set, WAY_W'(g)}].tag == lk_tag;
        assign sv_rank[g*RANK_W +: RANK_W] = ent_q[{lk_set, WAY_W'(g)}].rank;
    end

    logic             m_hit, m_vic_ok;
    logic [WAY_W-1:0] m_hit_way, m_vic_way;

    tagl_match #(.WAYS(WAYS), .RANK_W(RANK_W), .WAY_W(WAY_W)) u_match (
        .valid_i  (sv_valid),
        .lock_i   (sv_lock),
        .tag_eq_i (sv_eq),
        .rank_i   (sv_rank),
        .hit_o    (m_hit),
        .hit_way_o(m_hit_way),
        .vic_ok_o (m_vic_ok),
        .vic_way_o(m_vic_way)
    );

    logic             sel_hit, sel_ok, sel_dirty;
    logic [WAY_W-1:0] sel_way;

    always_comb begin
        if (one_way) begin
            sel_hit = sv_valid[lk_ow] && sv_eq[lk_ow];
            sel_ok  = sel_hit || !sv_lock[lk_ow];
            sel_way = lk_ow;
        end else begin
            sel_hit = m_hit;
            sel_ok  = m_hit || m_vic_ok;
            sel_way = m_hit ? m_hit_way : m_vic_way;
        end
        sel_dirty = sel_ok && sv_dirty[sel_way];
    end

    // ---------------- update / control decode ----------------
    logic [WAY_W-1:0] u_way, c_way;
    logic [IX_W-1:0]  u_ix, c_ix;
    assign u_way = one_way ? upd_addr[OFF_W+SET_W +: WAY_W] : upd_way;
    assign c_way = one_way ? ctl_addr[OFF_W+SET_W +: WAY_W] : ctl_way;
    assign u_ix  = {upd_addr[OFF_W +: SET_W], u_way};
    assign c_ix  = {ctl_addr[OFF_W +: SET_W], c_way};

    // ---------------- next state ----------------
    always_comb begin
        for (int i = 0; i < NENT; i++) ent_d[i] = ent_q[i];

        res_d.valid = lk_valid;
        res_d.hit   = lk_valid && sel_hit;
        res_d.ok    = lk_valid && sel_ok;
        res_d.way   = sel_way;
        res_d.dirty = lk_valid && sel_dirty;

        if (upd_valid) begin
            if (upd_fill) begin
                ent_d[u_ix].tag   = upd_addr[ADDR_W-1 -: TAG_W];
                ent_d[u_ix].valid = 1'b1;
                ent_d[u_ix].dirty = upd_dirty;
            end else begin
                ent_d[u_ix].dirty = ent_q[u_ix].dirty | upd_dirty;
            end
            if (!one_way) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (ent_q[{upd_addr[OFF_W +: SET_W], WAY_W'(w)}].rank > ent_q[u_ix].rank)
                        ent_d[{upd_addr[OFF_W +: SET_W], WAY_W'(w)}].rank =
                            ent_q[{upd_addr[OFF_W +: SET_W], WAY_W'(w)}].rank - RANK_W'(1);
                end
                ent_d[u_ix].rank = RANK_W'(WAYS);
            end
        end

        if (ctl_valid) begin
            case (ctl_op_e'(ctl_op))
                CTL_LOCK:   ent_d[c_ix].lock = 1'b1;
                CTL_UNLOCK: ent_d[c_ix].lock = 1'b0;
                CTL_INVAL: begin
                    ent_d[c_ix].valid = 1'b0;
                    ent_d[c_ix].dirty = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ent_q[i]      <= '0;
                ent_q[i].rank <= RANK_W'(i % WAYS);
            end
            res_q <= '0;
        end else begin
            for (int i = 0; i < NENT; i++) ent_q[i] <= ent_d[i];
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_hit    = res_q.hit;
    assign res_way_ok = res_q.ok;
    assign res_way    = res_q.way;
    assign res_dirty  = res_q.dirty;

    tagl_stats #(.CNT_W(CNT_W)) u_stats (
        .clk   (clk),
        .rst_n (rst_n),
        .look_i(lk_valid),
        .hit_i (sel_hit),
        .acc_o (acc_count),
        .hits_o(hit_count)
    );

    // ---------------- assertions ----------------
    p_res_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    p_res_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    p_mru_rank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !one_way) |=> ent_q[$past(u_ix)].rank == RANK_W'(WAYS));
    p_lock_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 2'd0) |=> ent_q[$past(c_ix)].lock);
    p_locked_no_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !sel_hit && !one_way && sv_lock[m_vic_way]) |=> !res_way_ok);
endmodule

// File: tb/test_tagl_lookup.sv
module test_tagl_lookup;
    localparam int SETS = 64;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        one_way = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [1:0]  upd_way = '0;
    logic        upd_fill = 1'b0;
    logic        upd_dirty = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [1:0]  ctl_op = 2'd3;
    logic [31:0] ctl_addr = '0;
    logic [1:0]  ctl_way = '0;
    logic        res_valid, res_hit, res_way_ok, res_dirty;
    logic [1:0]  res_way;
    logic [31:0] acc_count, hit_count;

    always #5 clk = ~clk;

    tagl_lookup i_tagl_lookup (
        .clk(clk), .rst_n(rst_n), .one_way(one_way),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_way(upd_way),
        .upd_fill(upd_fill), .upd_dirty(upd_dirty),
        .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_addr(ctl_addr), .ctl_way(ctl_way),
        .res_valid(res_valid), .res_hit(res_hit), .res_way_ok(res_way_ok),
        .res_way(res_way), .res_dirty(res_dirty),
        .acc_count(acc_count), .hit_count(hit_count)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input int t, input int s, input int o);
        return (32'(t) << 12) | (32'(s) << 6) | 32'(o);
    endfunction

    // ---------------- reference model ----------------
    int m_tag [SETS][WAYS];
    bit m_v   [SETS][WAYS];
    bit m_d   [SETS][WAYS];
    bit m_l   [SETS][WAYS];
    int m_r   [SETS][WAYS];
    bit e_valid, e_hit, e_ok, e_dirty;
    int e_way, e_acc, e_hits;

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_v[s][w] = 0; m_d[s][w] = 0; m_l[s][w] = 0; m_r[s][w] = w;
            end
        e_valid = 0; e_hit = 0; e_ok = 0; e_dirty = 0; e_way = 0; e_acc = 0; e_hits = 0;
    endtask

    task automatic model_look(input logic [31:0] a, input bit ow);
        int s, t, best;
        s = int'(a[11:6]);
        t = int'(a[31:12]);
        e_hit = 0; e_ok = 0; e_way = 0;
        if (ow) begin
            e_way = int'(a[13:12]);
            e_hit = m_v[s][e_way] && m_tag[s][e_way] == t;
            e_ok  = e_hit || !m_l[s][e_way];
        end else begin
            for (int w = 0; w < WAYS; w++)
                if (!e_hit && m_v[s][w] && m_tag[s][w] == t) begin e_hit = 1; e_way = w; end
            if (!e_hit) begin
                best = -1;
                for (int w = 0; w < WAYS; w++)
                    if (!m_l[s][w] && (best < 0 || m_r[s][w] < m_r[s][best])) best = w;
                e_ok = best >= 0;
                if (e_ok) e_way = best;
            end else e_ok = 1;
        end
        e_dirty = e_ok && m_d[s][e_way];
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int s, w, old;
            e_valid = lk_valid;
            if (lk_valid) begin
                model_look(lk_addr, one_way);
                e_acc++;
                if (e_hit) e_hits++;
            end
            if (upd_valid) begin
                s = int'(upd_addr[11:6]);
                w = one_way ? int'(upd_addr[13:12]) : int'(upd_way);
                if (upd_fill) begin
                    m_tag[s][w] = int'(upd_addr[31:12]); m_v[s][w] = 1; m_d[s][w] = upd_dirty;
                end else m_d[s][w] = m_d[s][w] | upd_dirty;
                if (!one_way) begin
                    old = m_r[s][w];
                    for (int k = 0; k < WAYS; k++) if (m_r[s][k] > old) m_r[s][k]--;
                    m_r[s][w] = WAYS;
                end
            end
            if (ctl_valid) begin
                s = int'(ctl_addr[11:6]);
                w = one_way ? int'(ctl_addr[13:12]) : int'(ctl_way);
                case (ctl_op)
                    2'd0: m_l[s][w] = 1;
                    2'd1: m_l[s][w] = 0;
                    2'd2: begin m_v[s][w] = 0; m_d[s][w] = 0; end
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 res_valid", int'(res_valid), int'(e_valid));
            if (e_valid) begin
                chk("R2 res_hit", int'(res_hit), int'(e_hit));
                chk("R4 res_way_ok", int'(res_way_ok), int'(e_ok));
                if (e_ok) begin
                    chk("R3 res_way", int'(res_way), e_way);
                    chk("R10 res_dirty", int'(res_dirty), int'(e_dirty));
                end
            end
            chk("R6 acc_count", int'(acc_count), e_acc);
            chk("R6 hit_count", int'(hit_count), e_hits);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        lk_valid = 0; upd_valid = 0; ctl_valid = 0;
    endtask

    task automatic look(input logic [31:0] a);
        lk_valid = 1; lk_addr = a;
    endtask

    task automatic upd(input logic [31:0] a, input int w, input bit f, input bit d);
        upd_valid = 1; upd_addr = a; upd_way = 2'(w); upd_fill = f; upd_dirty = d;
    endtask

    task automatic ctl(input logic [31:0] a, input int w, input int op);
        ctl_valid = 1; ctl_addr = a; ctl_way = 2'(w); ctl_op = 2'(op);
    endtask

    task automatic expect_res(input string rq, input bit h, input bit ok, input int w, input bit d);
        chk({rq, " hit"}, int'(res_hit), int'(h));
        chk({rq, " way_ok"}, int'(res_way_ok), int'(ok));
        if (ok) begin
            chk({rq, " way"}, int'(res_way), w);
            chk({rq, " dirty"}, int'(res_dirty), int'(d));
        end
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset res_valid", int'(res_valid), 0);
        chk("R7 reset acc", int'(acc_count), 0);
        chk("R7 reset hits", int'(hit_count), 0);
        rst_n = 1;
        @(negedge clk);

        look(mk(1, 0, 0)); step();
        expect_res("R7 empty set victim rank0", 0, 1, 0, 0);
        upd(mk(1, 0, 0), 0, 1, 1); step();
        look(mk(1, 0, 'h3c)); step();
        expect_res("R2 hit with offset R1", 1, 1, 0, 1);
        look(mk(1, 1, 0)); step();
        expect_res("R1 other set misses", 0, 1, 0, 0);
        look(mk(3, 0, 0)); step();
        expect_res("R5 victim after mru", 0, 1, 1, 0);

        ctl(mk(0, 0, 0), 1, 0); step();
        look(mk(2, 0, 0)); step();
        expect_res("R3 locked invalid skipped", 0, 1, 2, 0);
        ctl(mk(0, 0, 0), 0, 0); step();
        ctl(mk(0, 0, 0), 2, 0); step();
        ctl(mk(0, 0, 0), 3, 0); step();
        look(mk(2, 0, 0)); step();
        expect_res("R4 all locked", 0, 0, 0, 0);
        look(mk(1, 0, 0)); step();
        expect_res("R4 hit on locked way", 1, 1, 0, 1);

        ctl(mk(0, 0, 0), 0, 2); step();
        look(mk(1, 0, 0)); step();
        expect_res("R11 invalidated misses", 0, 0, 0, 0);
        ctl(mk(0, 0, 0), 0, 1); step();
        look(mk(1, 0, 0)); step();
        expect_res("R11 unlock, dirty cleared", 0, 1, 0, 0);

        upd(mk(5, 2, 0), 1, 1, 1); ctl(mk(0, 2, 0), 1, 2); step();
        look(mk(5, 2, 0)); step();
        expect_res("R12 control after update", 0, 1, 0, 0);
        look(mk(6, 3, 0)); upd(mk(6, 3, 0), 2, 1, 0); step();
        expect_res("R9 lookup sees old state", 0, 1, 0, 0);
        look(mk(6, 3, 0)); step();
        expect_res("R10 filled way hits", 1, 1, 2, 0);

        one_way = 1;
        upd(mk(7, 4, 0), 0, 1, 0); step();
        look(mk(7, 4, 0)); step();
        expect_res("R8 way from address", 1, 1, 3, 0);
        look(mk(4, 4, 0)); step();
        expect_res("R8 direct victim", 0, 1, 0, 0);
        one_way = 0;
        look(mk(7, 4, 0)); step();
        expect_res("R8 restored shape", 1, 1, 3, 0);

        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(99) < 70) look(mk($urandom_range(7), $urandom_range(3), $urandom_range(63)));
            if ($urandom_range(99) < 30)
                upd(mk($urandom_range(7), $urandom_range(3), 0), $urandom_range(3),
                    1'($urandom_range(1)), 1'($urandom_range(1)));
            if ($urandom_range(99) < 15)
                ctl(mk($urandom_range(7), $urandom_range(3), 0), $urandom_range(3), $urandom_range(3));
            if ($urandom_range(99) < 2) one_way = ~one_way;
            step();
        end
        step(); step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule